// File: doc/BRIEF.md
# Serial Bridge Command Decoder and UART Register Bank

This block sits behind a serial host bridge and interprets the byte stream that the host sends. Every transaction opens with a single command byte. That byte carries three things: the operation (read or write), the target (the data FIFO or the register bank) and, for register accesses, a 3-bit register address. A write command is followed by exactly one data byte. A read command makes the block return exactly one byte on an outbound byte stream.

The register bank holds three parts:
- Two 8-bit UART control registers, made of enable bits, mode bits and interrupt-enable bits.
- An 8-bit baud divisor.
- A third control register that has only a self-clearing soft-reset bit.

A read-only status register captures flags from the UART whenever that side pulses a load strobe. FIFO storage, the UART shifter and the serial framing all lie outside this block. FIFO traffic appears only as a push strobe with data, a pop strobe, and the head byte of the receive FIFO as an input.

Both byte streams use valid/ready handshakes, and a byte moves only in a cycle where both signals are high. While a read response is waiting, the inbound stream is held off with `in_ready` low, so the host cannot send the next command until the response has been taken. The outbound stream may be stalled indefinitely. During a stall, a register read response keeps its data unchanged.

Top module: `bridge_cmd_regs`

## Requirements
- R1: After reset the following values hold:
  - `ctrl1`, `ctrl2`, `baud_div` and `uart_soft_rst` are all zero.
  - A read of the status register returns 0x0B.
  - `in_ready` is 1 and `out_valid` is 0.
- R2: A command byte with bits 7..5 at zero, bit 4 = 1 (register target) and bit 3 = 1 (write) writes the following data byte into the register whose address is in bits 2..0. The address map is: 1 = control 1, 2 = control 2, 3 = baud divisor, 4 = control 3. The written value is on the matching output in the cycle after the data byte's handshake.
- R3: A register read command (bits 7..3 = 00010) is answered with `out_valid` high and the register value on `out_data`. While the response is not taken, `in_ready` stays low, `out_valid` stays high and `out_data` stays unchanged.
- R4: A FIFO write command (bits 7..3 = 00001) makes the following data byte produce a one-cycle `fifo_push`, with that byte on `fifo_push_data`, in the cycle of its handshake. Bits 2..0 of the command are ignored, and no register changes.
- R5: A FIFO read command (bits 7..3 = 00000, bits 2..0 ignored) returns `fifo_rd_data` on `out_data`. It pulses `fifo_pop` for one cycle in the cycle the response is taken.
- R6: A command byte with any of bits 7..5 set causes no register write, no FIFO push or pop, and no response. If its bit 3 is 1, the next inbound byte is swallowed as well.
- R7: The following accesses are ignored or return fixed values:
  - Writes to address 0 (status) leave its value unchanged.
  - Writes to addresses 5..7 have no effect.
  - Reads from addresses 5..7 return 0x00.
- R8: Control 3 implements only bit 7; its bits 6..0 read as zero. Writing a 1 to bit 7 sets `uart_soft_rst` high for exactly one cycle. At the end of that cycle, control 1, control 2, the baud divisor and the status register return to their R1 values, and the bit clears itself.
- R9: When `status_load` is high at a clock edge, the status register captures `status_flags`. A later status read returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound byte valid |
| in_ready | output | 1 | Block can take an inbound byte |
| in_data | input | 8 | Inbound command or data byte |
| out_valid | output | 1 | Read response byte valid |
| out_ready | input | 1 | Host takes the response byte |
| out_data | output | 8 | Read response byte |
| fifo_push | output | 1 | One-cycle push into the transmit FIFO |
| fifo_push_data | output | 8 | Byte to push |
| fifo_pop | output | 1 | One-cycle pop of the receive FIFO |
| fifo_rd_data | input | 8 | Head byte of the receive FIFO |
| status_load | input | 1 | Capture strobe for the status flags |
| status_flags | input | 8 | Status flags from the UART |
| ctrl1 | output | 8 | Control register 1 |
| ctrl2 | output | 8 | Control register 2 |
| baud_div | output | 8 | Baud divisor |
| uart_soft_rst | output | 1 | One-cycle UART soft reset |

## Verification
The hardest state to reach from the ports is the single cycle in which the soft-reset bit is high. Any later check sees only the restored values, so it cannot tell whether the bit ever set or cleared on time. The stimulus first loads non-reset values into every control register and into the status register. It then writes control 3 and samples `uart_soft_rst` and all control outputs on the two falling edges that follow. The stalled read response is reached by keeping `out_ready` low for several cycles after a read command is accepted.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTL1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTL2 = 3'd2;
  localparam logic [ADDR_W-1:0] A_BAUD = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTL3 = 3'd4;

  localparam logic [BYTE_W-1:0] STAT_RST = 8'h0B;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_WDATA = 2'd1,
    ST_RESP  = 2'd2,
    ST_DROP  = 2'd3
  } bstate_t;

  typedef struct packed {
    logic              bad;
    logic              is_reg;
    logic              is_wr;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

endpackage

// File: rtl/bridge_cmd_decode.sv
module bridge_cmd_decode
  import bridge_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_t              cmd
);
  always_comb begin
    cmd.bad    = |cmd_byte[7:5];
    cmd.is_reg = cmd_byte[4];
    cmd.is_wr  = cmd_byte[3];
    cmd.addr   = cmd_byte[ADDR_W-1:0];
  end
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  cmd_t              dec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              resp_fifo,
  output logic              rd_cap,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              fifo_push,
  output logic [BYTE_W-1:0] fifo_push_data,
  output logic              fifo_pop
);
  bstate_t state_q, state_d;
  cmd_t    cmd_q;
  logic    in_fire, out_fire;

  assign in_ready  = (state_q != ST_RESP);
  assign out_valid = (state_q == ST_RESP);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CMD: if (in_fire) begin
        if (dec.bad)        state_d = dec.is_wr ? ST_DROP : ST_CMD;
        else if (dec.is_wr) state_d = ST_WDATA;
        else                state_d = ST_RESP;
      end
      ST_WDATA: if (in_fire)  state_d = ST_CMD;
      ST_DROP:  if (in_fire)  state_d = ST_CMD;
      ST_RESP:  if (out_fire) state_d = ST_CMD;
      default:                state_d = ST_CMD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CMD && in_fire) cmd_q <= dec;
    end
  end

  assign rd_cap         = (state_q == ST_CMD) && in_fire && !dec.bad && !dec.is_wr && dec.is_reg;
  assign reg_we         = (state_q == ST_WDATA) && in_fire && cmd_q.is_reg;
  assign reg_waddr      = cmd_q.addr;
  assign reg_wdata      = in_data;
  assign fifo_push      = (state_q == ST_WDATA) && in_fire && !cmd_q.is_reg;
  assign fifo_push_data = in_data;
  assign fifo_pop       = out_fire && !cmd_q.is_reg;
  assign resp_fifo      = !cmd_q.is_reg;

  // R3
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_push, fifo_pop, reg_we}));

  // R6
  bad_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && in_fire && dec.bad) |=> (!out_valid && !fifo_push && !reg_we));

endmodule

// File: rtl/bridge_reg_bank.sv
module bridge_reg_bank
  import bridge_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BAUD_RST = 8'h00
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata,
  input  logic              status_load,
  input  logic [BYTE_W-1:0] status_flags,
  output logic [BYTE_W-1:0] ctrl1,
  output logic [BYTE_W-1:0] ctrl2,
  output logic [BYTE_W-1:0] baud_div,
  output logic              srst
);
  localparam int NCTL = 3;

  function automatic logic [BYTE_W-1:0] ctl_rst(input int idx);
    return (idx == NCTL - 1) ? BAUD_RST : '0;
  endfunction

  logic [BYTE_W-1:0] ctl_q [NCTL];
  logic [BYTE_W-1:0] status_q;
  logic              srst_q;

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n || srst_q)
        ctl_q[g] <= ctl_rst(g);
      else if (we && waddr == ADDR_W'(g + 1))
        ctl_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_q) status_q <= STAT_RST;
    else if (status_load) status_q <= status_flags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= we && (waddr == A_CTL3) && wdata[BYTE_W-1];
  end

  always_comb begin
    case (raddr)
      A_STAT:  rdata = status_q;
      A_CTL1:  rdata = ctl_q[0];
      A_CTL2:  rdata = ctl_q[1];
      A_BAUD:  rdata = ctl_q[2];
      A_CTL3:  rdata = {srst_q, {(BYTE_W-1){1'b0}}};
      default: rdata = '0;
    endcase
  end

  assign ctrl1    = ctl_q[0];
  assign ctrl2    = ctl_q[1];
  assign baud_div = ctl_q[2];
  assign srst     = srst_q;

  // R8
  srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);

  // R8
  srst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (ctl_q[0] == '0 && ctl_q[1] == '0 && ctl_q[2] == BAUD_RST && status_q == STAT_RST));

  // R7
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == A_STAT && !status_load && !srst_q) |=> $stable(status_q));

endmodule

// File: rtl/bridge_cmd_regs.sv
module bridge_cmd_regs
  import bridge_pkg::*;
#(
  parameter logic [7:0] BAUD_RST = 8'h00
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       fifo_push,
  output logic [7:0] fifo_push_data,
  output logic       fifo_pop,
  input  logic [7:0] fifo_rd_data,
  input  logic       status_load,
  input  logic [7:0] status_flags,
  output logic [7:0] ctrl1,
  output logic [7:0] ctrl2,
  output logic [7:0] baud_div,
  output logic       uart_soft_rst
);
  cmd_t              dec;
  logic              resp_fifo, rd_cap, reg_we;
  logic [ADDR_W-1:0] reg_waddr;
  logic [BYTE_W-1:0] reg_wdata, bank_rdata, rd_q;

  bridge_cmd_decode u_dec (
    .cmd_byte (in_data),
    .cmd      (dec)
  );

  bridge_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_data        (in_data),
    .dec            (dec),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .resp_fifo      (resp_fifo),
    .rd_cap         (rd_cap),
    .reg_we         (reg_we),
    .reg_waddr      (reg_waddr),
    .reg_wdata      (reg_wdata),
    .fifo_push      (fifo_push),
    .fifo_push_data (fifo_push_data),
    .fifo_pop       (fifo_pop)
  );

  bridge_reg_bank #(.BAUD_RST(BAUD_RST)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (reg_we),
    .waddr        (reg_waddr),
    .wdata        (reg_wdata),
    .raddr        (dec.addr),
    .rdata        (bank_rdata),
    .status_load  (status_load),
    .status_flags (status_flags),
    .ctrl1        (ctrl1),
    .ctrl2        (ctrl2),
    .baud_div     (baud_div),
    .srst         (uart_soft_rst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_cap) rd_q <= bank_rdata;
  end

  assign out_data = resp_fifo ? fifo_rd_data : rd_q;

  // R3
  stall_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !resp_fifo) |=> $stable(out_data));

endmodule

// File: tb/bridge_cmd_regs_test.sv
module bridge_cmd_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ready = 1'b0;
  logic [7:0] fifo_rd_data = 8'h00;
  logic       status_load = 1'b0;
  logic [7:0] status_flags = 8'h00;
  logic       in_ready, out_valid, fifo_push, fifo_pop, uart_soft_rst;
  logic [7:0] out_data, fifo_push_data, ctrl1, ctrl2, baud_div;

  int n_checks = 0;
  int n_fail = 0;
  int push_cnt = 0;
  int pop_cnt = 0;
  logic [7:0] push_last = 8'h00;

  always #2 clk = ~clk;

  bridge_cmd_regs uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fifo_push(fifo_push), .fifo_push_data(fifo_push_data), .fifo_pop(fifo_pop),
    .fifo_rd_data(fifo_rd_data), .status_load(status_load), .status_flags(status_flags),
    .ctrl1(ctrl1), .ctrl2(ctrl2), .baud_div(baud_div), .uart_soft_rst(uart_soft_rst)
  );

  always @(posedge clk) begin
    if (fifo_push) begin push_cnt++; push_last = fifo_push_data; end
    if (fifo_pop) pop_cnt++;
  end

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take(output logic [7:0] b);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    b = out_data;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] b);
    send({5'b00010, a});
    take(b);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
    send({5'b00011, a});
    send(v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(ctrl1 == 8'h00, "R1 ctrl1", ctrl1, 8'h00);
    check(ctrl2 == 8'h00, "R1 ctrl2", ctrl2, 8'h00);
    check(baud_div == 8'h00, "R1 baud", baud_div, 8'h00);
    check(uart_soft_rst == 1'b0, "R1 srst", {7'b0, uart_soft_rst}, 8'h00);
    check(in_ready && !out_valid, "R1 handshake", {6'b0, in_ready, out_valid}, 8'h02);
    rd_reg(3'd0, v);
    check(v == 8'h0B, "R1 status", v, 8'h0B);
  endtask

  task automatic t_reg_write();
    logic [7:0] v;
    wr_reg(3'd1, 8'hA5);
    check(ctrl1 == 8'hA5, "R2 ctrl1", ctrl1, 8'hA5);
    wr_reg(3'd2, 8'h3C);
    check(ctrl2 == 8'h3C, "R2 ctrl2", ctrl2, 8'h3C);
    wr_reg(3'd3, 8'h7E);
    check(baud_div == 8'h7E, "R2 baud", baud_div, 8'h7E);
    rd_reg(3'd1, v);
    check(v == 8'hA5, "R3 read ctrl1", v, 8'hA5);
    rd_reg(3'd2, v);
    check(v == 8'h3C, "R3 read ctrl2", v, 8'h3C);
  endtask

  task automatic t_backpressure();
    logic [7:0] v;
    send(8'h13);
    for (int i = 0; i < 3; i++) begin
      check(out_valid && !in_ready, "R3 stall flags", {6'b0, out_valid, in_ready}, 8'h02);
      check(out_data == 8'h7E, "R3 stall data", out_data, 8'h7E);
      @(negedge clk);
    end
    take(v);
    check(v == 8'h7E, "R3 taken data", v, 8'h7E);
    check(!out_valid && in_ready, "R3 release", {6'b0, out_valid, in_ready}, 8'h01);
  endtask

  task automatic t_fifo_write();
    int p0 = push_cnt;
    send(8'h0D);
    send(8'h5A);
    check(push_cnt == p0 + 1, "R4 push count", 8'(push_cnt - p0), 8'h01);
    check(push_last == 8'h5A, "R4 push data", push_last, 8'h5A);
    check(ctrl1 == 8'hA5 && baud_div == 8'h7E, "R4 regs untouched", ctrl1, 8'hA5);
  endtask

  task automatic t_fifo_read();
    logic [7:0] v;
    int q0 = pop_cnt;
    fifo_rd_data = 8'hC3;
    send(8'h07);
    check(pop_cnt == q0, "R5 no pop before take", 8'(pop_cnt - q0), 8'h00);
    take(v);
    check(v == 8'hC3, "R5 fifo data", v, 8'hC3);
    check(pop_cnt == q0 + 1, "R5 pop count", 8'(pop_cnt - q0), 8'h01);
  endtask

  task automatic t_bad_cmd();
    logic [7:0] v;
    int p0 = push_cnt;
    send(8'h39);
    send(8'hFF);
    check(ctrl1 == 8'hA5, "R6 bad write ctrl1", ctrl1, 8'hA5);
    check(push_cnt == p0, "R6 bad write push", 8'(push_cnt - p0), 8'h00);
    send(8'h80);
    @(negedge clk);
    check(!out_valid, "R6 bad read no response", {7'b0, out_valid}, 8'h00);
    send(8'hA8);
    send(8'h11);
    check(push_cnt == p0 && !out_valid, "R6 swallowed byte", 8'(push_cnt - p0), 8'h00);
    rd_reg(3'd1, v);
    check(v == 8'hA5, "R6 recovery", v, 8'hA5);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    wr_reg(3'd0, 8'h55);
    rd_reg(3'd0, v);
    check(v == 8'h0B, "R7 status write ignored", v, 8'h0B);
    wr_reg(3'd5, 8'hFF);
    check(ctrl1 == 8'hA5 && ctrl2 == 8'h3C && baud_div == 8'h7E, "R7 unused write", ctrl2, 8'h3C);
    rd_reg(3'd5, v);
    check(v == 8'h00, "R7 read addr5", v, 8'h00);
    rd_reg(3'd7, v);
    check(v == 8'h00, "R7 read addr7", v, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    @(negedge clk);
    status_flags = 8'h5C; status_load = 1'b1;
    @(negedge clk);
    status_load = 1'b0; status_flags = 8'hFF;
    rd_reg(3'd0, v);
    check(v == 8'h5C, "R9 status capture", v, 8'h5C);
  endtask

  task automatic t_soft_reset();
    logic [7:0] v;
    wr_reg(3'd4, 8'h7F);
    check(uart_soft_rst == 1'b0, "R8 low bits no reset", {7'b0, uart_soft_rst}, 8'h00);
    rd_reg(3'd4, v);
    check(v == 8'h00, "R8 ctrl3 reads zero", v, 8'h00);
    wr_reg(3'd4, 8'h80);
    check(uart_soft_rst == 1'b1, "R8 pulse high", {7'b0, uart_soft_rst}, 8'h01);
    check(ctrl1 == 8'hA5, "R8 regs before restore", ctrl1, 8'hA5);
    @(negedge clk);
    check(uart_soft_rst == 1'b0, "R8 self clear", {7'b0, uart_soft_rst}, 8'h00);
    check(ctrl1 == 8'h00, "R8 ctrl1 restored", ctrl1, 8'h00);
    check(ctrl2 == 8'h00, "R8 ctrl2 restored", ctrl2, 8'h00);
    check(baud_div == 8'h00, "R8 baud restored", baud_div, 8'h00);
    rd_reg(3'd0, v);
    check(v == 8'h0B, "R8 status restored", v, 8'h0B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_write();
    t_backpressure();
    t_fifo_write();
    t_fifo_read();
    t_bad_cmd();
    t_ignored();
    t_status();
    t_soft_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule